// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block keeps a four-bank DRAM of 4096 rows per bank refreshed. While the host owns the device, an interval timer raises an auto-refresh request. The request stays up until the bank controller acknowledges it, and each acknowledge moves a 12-bit row counter on by one. The host can drop the clock-enable input to put the device into power-down. If it issues a refresh command while clock enable is low, the block enters self-refresh instead.

In self-refresh the block works on its own. It emits one refresh slot per period, naming a row and a bank. The period is chosen from four settings, each one double the last. A bank mask limits the slots to the banks whose contents must survive, and masked banks use no slot. The row counter moves on only after the last enabled bank of a row has been refreshed. Raising clock enable leaves self-refresh, and the row counter keeps its value across both entry and exit.

Top module: `refresh_sched`

## Requirements
- R1: After reset, arReq, srPulse, selfRefresh and powerDown are 0 and refRow is 0.
- R2: With autoEn high and the block not in self-refresh, arReq rises after arInterval clock edges. Once raised, it stays high until it is acknowledged, even if autoEn is then dropped.
- R3: An arAck on an edge where arReq is high clears arReq and adds one to refRow. An arAck while arReq is low changes neither.
- R4: refRow wraps from 4095 to 0. It changes only on an acknowledged request or a self-refresh slot, so it keeps its value across self-refresh entry and exit.
- R5: With cke low and no refCmd, powerDown is 1 from the next edge. Raising cke clears powerDown at the next edge.
- R6: A refCmd while cke is low sets selfRefresh at the next edge, from either the active or the power-down state. Any pending arReq is dropped at that edge, and arReq stays low during self-refresh.
- R7: In self-refresh, srPulse is high for one cycle every P cycles, where P = 64 << srPeriodSel (srPeriodSel 0,1,2,3 gives 64, 128, 256, 512). The first slot falls in the P-th cycle of self-refresh.
- R8: Bit i of bankMask enables bank i. Slots visit the enabled banks in ascending order, with refBank naming the bank and refRow the row, and masked banks use no slot. The row moves on after the highest enabled bank. With a mask of 0 there are no slots and refRow does not change.
- R9: Raising cke in self-refresh clears selfRefresh at the next edge. Every self-refresh entry restarts the bank order at the lowest enabled bank of the current row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable from the host; low selects power-down or self-refresh |
| refCmd | input | 1 | Refresh command; enters self-refresh when cke is low |
| autoEn | input | 1 | Runs the auto-refresh interval timer |
| arInterval | input | 16 | Auto-refresh interval in cycles (minimum 1) |
| arAck | input | 1 | Bank controller accepted the pending request |
| srPeriodSel | input | 2 | Self-refresh period step |
| bankMask | input | 4 | Banks kept alive in self-refresh |
| arReq | output | 1 | Pending auto-refresh request |
| srPulse | output | 1 | Self-refresh slot strobe |
| refRow | output | 12 | Row to refresh |
| refBank | output | 2 | Bank of the current self-refresh slot (0 outside self-refresh) |
| selfRefresh | output | 1 | Block is in self-refresh |
| powerDown | output | 1 | Block is in power-down |

## Verification
The hardest case to reach from the ports is a self-refresh exit in the middle of a row, with the internal bank order left pointing past the first enabled bank. The stimulus runs six slots with all banks enabled, which leaves the order at bank 2 of row 1. It then re-enters with a sparse mask and expects bank 1 first. Reaching the row wrap takes 4096 acknowledged requests, so the stimulus sets a one-cycle interval and holds the acknowledge high.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_PDOWN  = 2'd1,
    ST_SREF   = 2'd2
  } modeT;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;   // restart the interval timer
    logic loadSr;   // reload value uses the self-refresh period
    logic srRun;    // currently in self-refresh
    logic autoRun;  // auto-refresh timer may tick
    logic dropReq;  // entering self-refresh: discard pending request
  } ctlStrobeT;

endpackage

// File: rtl/refresh_ctl.sv
module refresh_ctl
  import refresh_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cke,
  input  logic      refCmd,
  input  logic      autoEn,
  output ctlStrobeT strobe,
  output logic      selfRefresh,
  output logic      powerDown
);

  modeT state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_ACTIVE, ST_PDOWN: begin
        if (!cke && refCmd) nxt = ST_SREF;
        else if (!cke)      nxt = ST_PDOWN;
        else                nxt = ST_ACTIVE;
      end
      ST_SREF: if (cke) nxt = ST_ACTIVE;
      default: nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nxt;
  end

  always_comb begin
    strobe.srRun   = (state == ST_SREF);
    strobe.loadSr  = (nxt == ST_SREF);
    strobe.reload  = (strobe.srRun != strobe.loadSr) || (!strobe.loadSr && !autoEn);
    strobe.autoRun = !strobe.srRun && autoEn;
    strobe.dropReq = strobe.loadSr && !strobe.srRun;
  end

  assign selfRefresh = (state == ST_SREF);
  assign powerDown   = (state == ST_PDOWN);

  a_r5_pdown_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!selfRefresh && !cke && !refCmd) |=> powerDown);
  a_r5_pdown_exit: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && cke) |=> !powerDown);
  a_r6_sref_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && refCmd) |=> selfRefresh);
  a_r9_sref_exit: assert property (@(posedge clk) disable iff (!rstN)
    (selfRefresh && cke) |=> !selfRefresh);
  a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(selfRefresh && powerDown));

endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int BANKS   = 4,
  parameter int BANK_W  = 2,
  parameter int INT_W   = 16,
  parameter int SR_BASE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [INT_W-1:0]  arInterval,
  input  logic [1:0]        srPeriodSel,
  input  logic [BANKS-1:0]  bankMask,
  input  logic              arAck,
  output logic              arReq,
  output logic              srPulse,
  output logic [ROW_W-1:0]  refRow,
  output logic [BANK_W-1:0] refBank
);

  logic [INT_W-1:0]  tmr, reloadVal;
  logic [BANK_W-1:0] ptr, hitBank;
  logic              found, more, tmrZero, srSlot, autoTick, ackTaken, srRowStep;

  always_comb begin
    if (strobe.loadSr) reloadVal = (INT_W'(SR_BASE) << srPeriodSel) - INT_W'(1);
    else               reloadVal = arInterval - INT_W'(1);
  end

  // first enabled bank at or above the pointer, and whether one lies above it
  always_comb begin
    found   = 1'b0;
    hitBank = '0;
    for (int i = 0; i < BANKS; i++) begin
      if (!found && bankMask[i] && (BANK_W'(i) >= ptr)) begin
        found   = 1'b1;
        hitBank = BANK_W'(i);
      end
    end
    more = 1'b0;
    for (int i = 0; i < BANKS; i++) begin
      if (bankMask[i] && (BANK_W'(i) > hitBank)) more = 1'b1;
    end
  end

  assign tmrZero   = (tmr == '0);
  assign srSlot    = strobe.srRun && tmrZero;
  assign srPulse   = srSlot && found;
  assign autoTick  = strobe.autoRun && !strobe.reload && tmrZero;
  assign ackTaken  = arReq && arAck;
  assign srRowStep = srSlot && (found ? !more : (bankMask != '0));
  assign refBank   = strobe.srRun ? hitBank : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr    <= '1;
      arReq  <= 1'b0;
      ptr    <= '0;
      refRow <= '0;
    end else begin
      if (strobe.reload || tmrZero) tmr <= reloadVal;
      else                          tmr <= tmr - INT_W'(1);

      if (strobe.dropReq) arReq <= 1'b0;
      else                arReq <= autoTick || (arReq && !arAck);

      if (strobe.reload && strobe.loadSr) ptr <= '0;
      else if (srSlot && (bankMask != '0)) begin
        if (found && more) ptr <= hitBank + BANK_W'(1);
        else               ptr <= '0;
      end

      if (ackTaken || srRowStep) refRow <= refRow + ROW_W'(1);
    end
  end

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (arReq && !arAck && !strobe.dropReq) |=> arReq);
  a_r3_ack_step: assert property (@(posedge clk) disable iff (!rstN)
    (arReq && arAck) |=> (refRow == ROW_W'($past(refRow) + ROW_W'(1))));
  a_r4_row_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (arReq && arAck && (refRow == '1)) |=> (refRow == '0));
  a_r4_row_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.srRun && !(arReq && arAck)) |=> $stable(refRow));
  a_r6_no_req_in_sref: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srRun |-> !arReq);
  a_r8_bank_enabled: assert property (@(posedge clk) disable iff (!rstN)
    srPulse |-> bankMask[refBank]);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int ROWS    = 4096,
  parameter int BANKS   = 4,
  parameter int INT_W   = 16,
  parameter int SR_BASE = 64,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              refCmd,
  input  logic              autoEn,
  input  logic [INT_W-1:0]  arInterval,
  input  logic              arAck,
  input  logic [1:0]        srPeriodSel,
  input  logic [BANKS-1:0]  bankMask,
  output logic              arReq,
  output logic              srPulse,
  output logic [ROW_W-1:0]  refRow,
  output logic [BANK_W-1:0] refBank,
  output logic              selfRefresh,
  output logic              powerDown
);

  ctlStrobeT strobe;

  refresh_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cke         (cke),
    .refCmd      (refCmd),
    .autoEn      (autoEn),
    .strobe      (strobe),
    .selfRefresh (selfRefresh),
    .powerDown   (powerDown)
  );

  refresh_dp #(
    .ROW_W   (ROW_W),
    .BANKS   (BANKS),
    .BANK_W  (BANK_W),
    .INT_W   (INT_W),
    .SR_BASE (SR_BASE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .arInterval  (arInterval),
    .srPeriodSel (srPeriodSel),
    .bankMask    (bankMask),
    .arAck       (arAck),
    .arReq       (arReq),
    .srPulse     (srPulse),
    .refRow      (refRow),
    .refBank     (refBank)
  );

endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;

  localparam int ROW_W = 12;
  localparam int BANK_W = 2;
  localparam int BASE = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, refCmd = 1'b0, autoEn = 1'b0, arAck = 1'b0;
  logic [15:0] arInterval = 16'd5;
  logic [1:0] srPeriodSel = 2'd0;
  logic [3:0] bankMask = 4'hF;
  logic arReq, srPulse, selfRefresh, powerDown;
  logic [ROW_W-1:0] refRow;
  logic [BANK_W-1:0] refBank;

  int nChecks = 0;
  int nErrors = 0;
  int expPeriod = BASE;
  int gapCnt = 0;
  int strays = 0;
  logic [ROW_W+BANK_W-1:0] q[$];
  logic [ROW_W-1:0] expRow = '0;

  always #4 clk = ~clk;

  refresh_sched u_dut (
    .clk(clk), .rstN(rstN), .cke(cke), .refCmd(refCmd), .autoEn(autoEn),
    .arInterval(arInterval), .arAck(arAck), .srPeriodSel(srPeriodSel),
    .bankMask(bankMask), .arReq(arReq), .srPulse(srPulse), .refRow(refRow),
    .refBank(refBank), .selfRefresh(selfRefresh), .powerDown(powerDown)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected slots and checks slot spacing (R7, R8)
  always @(negedge clk) begin
    if (rstN) begin
      if (selfRefresh) gapCnt++;
      else             gapCnt = 0;
      if (srPulse) begin
        if (q.size() == 0) begin
          strays++;
          nErrors++;
          nChecks++;
          $display("FAIL R8 stray slot: actual row=%0d bank=%0d expected=none", refRow, refBank);
        end else begin
          logic [ROW_W+BANK_W-1:0] it;
          it = q.pop_front();
          check("R8", "slot row", int'(refRow), int'(it[ROW_W+BANK_W-1:BANK_W]));
          check("R8", "slot bank", int'(refBank), int'(it[BANK_W-1:0]));
          check("R7", "slot spacing", gapCnt, expPeriod);
        end
        gapCnt = 0;
      end
    end
  end

  // Driver: enter self-refresh, push expected slots, leave after they are seen
  task automatic runSelf(input logic [3:0] mask, input logic [1:0] sel, input int nSlots);
    int ptr = 0;
    for (int s = 0; s < nSlots; s++) begin
      int bank = -1;
      bit more = 0;
      for (int b = 0; b < 4; b++) if (bank < 0 && mask[b] && b >= ptr) bank = b;
      for (int b = 0; b < 4; b++) if (mask[b] && b > bank) more = 1;
      q.push_back({expRow, BANK_W'(bank)});
      if (more) ptr = bank + 1;
      else begin ptr = 0; expRow = expRow + 1'b1; end
    end
    @(negedge clk);
    expPeriod = BASE << sel;
    bankMask = mask;
    srPeriodSel = sel;
    cke = 1'b0;
    refCmd = 1'b1;
    @(negedge clk);
    refCmd = 1'b0;
    check("R6", "selfRefresh after entry", int'(selfRefresh), 1);
    check("R6", "arReq in self-refresh", int'(arReq), 0);
    wait (q.size() == 0);
    @(negedge clk);
    cke = 1'b1;
    @(negedge clk);
    check("R9", "selfRefresh after exit", int'(selfRefresh), 0);
    check("R4", "row held across self-refresh", int'(refRow), int'(expRow));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "arReq reset", int'(arReq), 0);
    check("R1", "refRow reset", int'(refRow), 0);
    check("R1", "selfRefresh reset", int'(selfRefresh), 0);
    check("R1", "powerDown reset", int'(powerDown), 0);
    check("R1", "srPulse reset", int'(srPulse), 0);

    // R2: request timing and holding
    arInterval = 16'd5;
    @(negedge clk);
    autoEn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2", "arReq before interval", int'(arReq), 0);
    @(negedge clk);
    check("R2", "arReq at interval", int'(arReq), 1);
    autoEn = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "arReq held without ack", int'(arReq), 1);

    // R3: acknowledge advances, stray ack ignored
    arAck = 1'b1;
    @(negedge clk);
    arAck = 1'b0;
    check("R3", "row after ack", int'(refRow), 1);
    check("R3", "arReq cleared by ack", int'(arReq), 0);
    arAck = 1'b1;
    @(negedge clk);
    arAck = 1'b0;
    check("R3", "row after stray ack", int'(refRow), 1);
    check("R3", "arReq after stray ack", int'(arReq), 0);

    // R5: power-down
    cke = 1'b0;
    @(negedge clk);
    check("R5", "powerDown entry", int'(powerDown), 1);
    check("R5", "no selfRefresh in power-down", int'(selfRefresh), 0);
    cke = 1'b1;
    @(negedge clk);
    check("R5", "powerDown exit", int'(powerDown), 0);

    // R4: row wrap with back-to-back acknowledged requests
    arInterval = 16'd1;
    autoEn = 1'b1;
    arAck = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (refRow == 12'd4095) break;
    end
    check("R4", "row reached 4095", int'(refRow), 4095);
    @(negedge clk);
    arAck = 1'b0;
    autoEn = 1'b0;
    check("R4", "row wrapped to 0", int'(refRow), 0);
    expRow = '0;
    @(negedge clk);
    check("R6", "request pending before entry", int'(arReq), 1);

    // R6/R7/R8: all banks, shortest period; exit mid-row (bank order at 2)
    runSelf(4'b1111, 2'd0, 6);
    // R9: re-entry restarts at lowest enabled bank (bank 1, not bank 3)
    runSelf(4'b1010, 2'd2, 5);
    runSelf(4'b1000, 2'd1, 3);
    check("R8", "row after sparse masks", int'(refRow), 6);

    // R8: empty mask makes no slots and keeps the row
    @(negedge clk);
    bankMask = 4'b0000;
    srPeriodSel = 2'd0;
    cke = 1'b0;
    refCmd = 1'b1;
    @(negedge clk);
    refCmd = 1'b0;
    check("R6", "entry from active", int'(selfRefresh), 1);
    repeat (300) @(negedge clk);
    check("R8", "no slots with empty mask", strays, 0);
    check("R8", "row unchanged with empty mask", int'(refRow), 6);
    cke = 1'b1;
    @(negedge clk);
    check("R9", "exit after empty mask", int'(selfRefresh), 0);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule